// File: doc/BRIEF.md
# Guest Event Intercept Decision Unit

This unit sits beside a processor core that runs guest software under a hypervisor. For each guest event it decides whether the event must leave the guest and return control to the hypervisor. An event is an exit code and a 64-bit parameter. On guest entry, a single-cycle entry strobe loads a set of intercept masks and sets the unit's enable flag. When the guest is left, a leave strobe clears the enable flag, the generic vector and the exception mask.

The exit code selects the mask that decides the event. A small code range selects a control-register-read mask or a control-register-write mask. Other ranges select a debug-register-read mask, a debug-register-write mask or a 32-bit exception mask. Codes from the interrupt base upward index a 64-bit generic vector. The bit tested is always the code minus the base of its class. A code that falls inside no class never exits. A positive decision is registered and appears one cycle after the event, carrying the event's code and parameter as the exit code and the first exit-information word.

Top module: `intercept_unit`

## Requirements
- R1: While the enable flag is clear (after reset or after a leave strobe), no event produces an exit, whatever the masks hold.
- R2: Codes 0x000 to 0x008 exit when bit (code - 0x000) of the 16-bit control-register-read mask is set; bits 9 to 15 of that mask are never consulted.
- R3: Codes 0x010 to 0x018 exit when bit (code - 0x010) of the 16-bit control-register-write mask is set.
- R4: Codes 0x020 to 0x027 use bit (code - 0x020) of the debug-register-read mask. Codes 0x030 to 0x037 use bit (code - 0x030) of the debug-register-write mask. Codes 0x028 to 0x02F and 0x038 to 0x03F never exit.
- R5: Codes 0x040 to 0x05F exit when bit (code - 0x040) of the 32-bit exception mask is set.
- R6: Codes 0x060 to 0x09F exit when bit (code - 0x060) of the 64-bit generic vector is set. Codes that are in no class (0x009 to 0x00F, 0x019 to 0x01F, above 0x09F) never exit.
- R7: An exit reports the event's code on exit_code_o and its parameter on exit_info_o.
- R8: A leave strobe clears the enable flag, the generic vector and the exception mask. Events after it produce no exit until the next entry strobe.
- R9: An entry strobe loads all masks and sets the enable flag. An event in the same cycle as the strobe is decided by the previous masks and enable flag. When leave and entry strobes coincide, the leave strobe wins.
- R10: exit_valid_o is high for exactly one cycle, in the cycle after a valid event that exits. Events on consecutive cycles each give their own exit. exit_code_o and exit_info_o hold their last values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_i | input | 1 | Guest-entry strobe: load masks, set enable |
| enter_generic_i | input | 64 | Generic intercept vector to load |
| enter_cr_rd_i | input | 16 | Control-register-read mask to load |
| enter_cr_wr_i | input | 16 | Control-register-write mask to load |
| enter_dr_rd_i | input | 16 | Debug-register-read mask to load |
| enter_dr_wr_i | input | 16 | Debug-register-write mask to load |
| enter_exc_i | input | 32 | Exception mask to load |
| leave_i | input | 1 | Guest-leave strobe |
| evt_valid_i | input | 1 | Event present this cycle |
| evt_code_i | input | 12 | Event exit code |
| evt_param_i | input | 64 | Event parameter |
| exit_valid_o | output | 1 | Exit request pulse |
| exit_code_o | output | 12 | Reported exit code |
| exit_info_o | output | 64 | Reported first exit-information word |

## Verification
Several properties are checked on every cycle: an exit never follows a cycle in which enable was clear or no event was presented; the reported code and parameter match the event of the previous cycle; any exit code lies inside a class range; leave clears enable; and a lone entry strobe sets enable. Only the bench scenarios can show that the right mask bit is chosen for each class. These scenarios cover class edges, the unused high mask bits, codes between classes, same-cycle entry with an event, and coincident strobes.

// File: rtl/icpt_pkg.sv
package icpt_pkg;
    localparam int CR_RD_BASE = 'h000;
    localparam int CR_WR_BASE = 'h010;
    localparam int DR_RD_BASE = 'h020;
    localparam int DR_WR_BASE = 'h030;
    localparam int EXC_BASE   = 'h040;
    localparam int GEN_BASE   = 'h060;
    localparam int CR_SPAN    = 9;
    localparam int DR_SPAN    = 8;
    localparam int EXC_SPAN   = 32;
    localparam int GEN_SPAN   = 64;
endpackage

// File: rtl/icpt_range_sel.sv
module icpt_range_sel #(
    parameter int CODE_W = 12,
    parameter int BASE   = 0,
    parameter int SPAN   = 8,
    parameter int MASK_W = 16
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              hit_o
);
    localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;
    localparam logic [CODE_W-1:0] LO   = CODE_W'(BASE);
    localparam logic [CODE_W-1:0] SPANV = CODE_W'(SPAN);

    logic [CODE_W-1:0] offs;
    logic              in_class;

    // wrap-around subtraction: codes below the base become large and fail the span test
    always_comb begin
        offs     = code_i - LO;
        in_class = (offs < SPANV);
        hit_o    = in_class && mask_i[offs[IDX_W-1:0]];
    end
endmodule

// File: rtl/icpt_decode.sv
module icpt_decode #(
    parameter int CODE_W = 12,
    parameter int GEN_W  = 64,
    parameter int CR_W   = 16,
    parameter int DR_W   = 16,
    parameter int EXC_W  = 32
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [CR_W-1:0]   cr_rd_i,
    input  logic [CR_W-1:0]   cr_wr_i,
    input  logic [DR_W-1:0]   dr_rd_i,
    input  logic [DR_W-1:0]   dr_wr_i,
    input  logic [EXC_W-1:0]  exc_i,
    input  logic [GEN_W-1:0]  gen_i,
    output logic              hit_o
);
    import icpt_pkg::*;

    localparam int NCLS = 6;
    logic [NCLS-1:0] cls_hit;

    icpt_range_sel #(.CODE_W(CODE_W), .BASE(CR_RD_BASE), .SPAN(CR_SPAN), .MASK_W(CR_W))
        u_cr_rd (.code_i(code_i), .mask_i(cr_rd_i), .hit_o(cls_hit[0]));
    icpt_range_sel #(.CODE_W(CODE_W), .BASE(CR_WR_BASE), .SPAN(CR_SPAN), .MASK_W(CR_W))
        u_cr_wr (.code_i(code_i), .mask_i(cr_wr_i), .hit_o(cls_hit[1]));
    icpt_range_sel #(.CODE_W(CODE_W), .BASE(DR_RD_BASE), .SPAN(DR_SPAN), .MASK_W(DR_W))
        u_dr_rd (.code_i(code_i), .mask_i(dr_rd_i), .hit_o(cls_hit[2]));
    icpt_range_sel #(.CODE_W(CODE_W), .BASE(DR_WR_BASE), .SPAN(DR_SPAN), .MASK_W(DR_W))
        u_dr_wr (.code_i(code_i), .mask_i(dr_wr_i), .hit_o(cls_hit[3]));
    icpt_range_sel #(.CODE_W(CODE_W), .BASE(EXC_BASE), .SPAN(EXC_SPAN), .MASK_W(EXC_W))
        u_exc (.code_i(code_i), .mask_i(exc_i), .hit_o(cls_hit[4]));
    icpt_range_sel #(.CODE_W(CODE_W), .BASE(GEN_BASE), .SPAN(GEN_SPAN), .MASK_W(GEN_W))
        u_gen (.code_i(code_i), .mask_i(gen_i), .hit_o(cls_hit[5]));

    // class ranges do not overlap, so at most one bit can be set
    assign hit_o = |cls_hit;
endmodule

// File: rtl/intercept_unit.sv
module intercept_unit #(
    parameter int CODE_W = 12,
    parameter int INFO_W = 64,
    parameter int GEN_W  = 64,
    parameter int CR_W   = 16,
    parameter int DR_W   = 16,
    parameter int EXC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_i,
    input  logic [GEN_W-1:0]  enter_generic_i,
    input  logic [CR_W-1:0]   enter_cr_rd_i,
    input  logic [CR_W-1:0]   enter_cr_wr_i,
    input  logic [DR_W-1:0]   enter_dr_rd_i,
    input  logic [DR_W-1:0]   enter_dr_wr_i,
    input  logic [EXC_W-1:0]  enter_exc_i,
    input  logic              leave_i,
    input  logic              evt_valid_i,
    input  logic [CODE_W-1:0] evt_code_i,
    input  logic [INFO_W-1:0] evt_param_i,
    output logic              exit_valid_o,
    output logic [CODE_W-1:0] exit_code_o,
    output logic [INFO_W-1:0] exit_info_o
);
    typedef struct packed {
        logic              en;
        logic [GEN_W-1:0]  gen;
        logic [CR_W-1:0]   cr_rd;
        logic [CR_W-1:0]   cr_wr;
        logic [DR_W-1:0]   dr_rd;
        logic [DR_W-1:0]   dr_wr;
        logic [EXC_W-1:0]  exc;
        logic              xv;
        logic [CODE_W-1:0] xcode;
        logic [INFO_W-1:0] xinfo;
    } st_t;

    localparam st_t ST_RESET = '0;

    st_t  st_d, st_q;
    logic mask_hit;
    logic guest_en_q;

    icpt_decode #(
        .CODE_W(CODE_W), .GEN_W(GEN_W), .CR_W(CR_W), .DR_W(DR_W), .EXC_W(EXC_W)
    ) u_dec (
        .code_i (evt_code_i),
        .cr_rd_i(st_q.cr_rd),
        .cr_wr_i(st_q.cr_wr),
        .dr_rd_i(st_q.dr_rd),
        .dr_wr_i(st_q.dr_wr),
        .exc_i  (st_q.exc),
        .gen_i  (st_q.gen),
        .hit_o  (mask_hit)
    );

    always_comb begin
        st_d    = st_q;
        st_d.xv = 1'b0;
        // decision uses the masks held at the start of this cycle
        if (evt_valid_i && st_q.en && mask_hit) begin
            st_d.xv    = 1'b1;
            st_d.xcode = evt_code_i;
            st_d.xinfo = evt_param_i;
        end
        if (leave_i) begin
            st_d.en  = 1'b0;
            st_d.gen = '0;
            st_d.exc = '0;
        end else if (enter_i) begin
            st_d.en    = 1'b1;
            st_d.gen   = enter_generic_i;
            st_d.cr_rd = enter_cr_rd_i;
            st_d.cr_wr = enter_cr_wr_i;
            st_d.dr_rd = enter_dr_rd_i;
            st_d.dr_wr = enter_dr_wr_i;
            st_d.exc   = enter_exc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign guest_en_q   = st_q.en;
    assign exit_valid_o = st_q.xv;
    assign exit_code_o  = st_q.xcode;
    assign exit_info_o  = st_q.xinfo;
endmodule

// File: rtl/intercept_unit_chk.sv
module intercept_unit_chk #(
    parameter int CODE_W = 12,
    parameter int INFO_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enter_i,
    input logic              leave_i,
    input logic              evt_valid_i,
    input logic [CODE_W-1:0] evt_code_i,
    input logic [INFO_W-1:0] evt_param_i,
    input logic              exit_valid_o,
    input logic [CODE_W-1:0] exit_code_o,
    input logic [INFO_W-1:0] exit_info_o,
    input logic              guest_en_q
);
    // R1
    exit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid_o |-> $past(guest_en_q));

    // R10
    exit_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid_o |-> $past(evt_valid_i));

    // R7
    exit_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid_o |-> (exit_code_o == $past(evt_code_i)) && (exit_info_o == $past(evt_param_i)));

    // R6
    exit_code_in_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid_o |-> (exit_code_o <= CODE_W'(12'h008))
                      || (exit_code_o >= CODE_W'(12'h010) && exit_code_o <= CODE_W'(12'h018))
                      || (exit_code_o >= CODE_W'(12'h020) && exit_code_o <= CODE_W'(12'h027))
                      || (exit_code_o >= CODE_W'(12'h030) && exit_code_o <= CODE_W'(12'h037))
                      || (exit_code_o >= CODE_W'(12'h040) && exit_code_o <= CODE_W'(12'h09F)));

    // R8
    leave_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        leave_i |=> !guest_en_q);

    // R9
    enter_sets_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && !leave_i) |=> guest_en_q);
endmodule

bind intercept_unit intercept_unit_chk #(.CODE_W(CODE_W), .INFO_W(INFO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_i     (enter_i),
    .leave_i     (leave_i),
    .evt_valid_i (evt_valid_i),
    .evt_code_i  (evt_code_i),
    .evt_param_i (evt_param_i),
    .exit_valid_o(exit_valid_o),
    .exit_code_o (exit_code_o),
    .exit_info_o (exit_info_o),
    .guest_en_q  (guest_en_q)
);

// File: tb/intercept_unit_test.sv
module intercept_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_i = 1'b0;
    logic [63:0] enter_generic_i = '0;
    logic [15:0] enter_cr_rd_i = '0, enter_cr_wr_i = '0;
    logic [15:0] enter_dr_rd_i = '0, enter_dr_wr_i = '0;
    logic [31:0] enter_exc_i = '0;
    logic        leave_i = 1'b0;
    logic        evt_valid_i = 1'b0;
    logic [11:0] evt_code_i = '0;
    logic [63:0] evt_param_i = '0;
    logic        exit_valid_o;
    logic [11:0] exit_code_o;
    logic [63:0] exit_info_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [11:0] code;
        logic [63:0] param;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    intercept_unit uut (
        .clk(clk), .rst_n(rst_n),
        .enter_i(enter_i), .enter_generic_i(enter_generic_i),
        .enter_cr_rd_i(enter_cr_rd_i), .enter_cr_wr_i(enter_cr_wr_i),
        .enter_dr_rd_i(enter_dr_rd_i), .enter_dr_wr_i(enter_dr_wr_i),
        .enter_exc_i(enter_exc_i), .leave_i(leave_i),
        .evt_valid_i(evt_valid_i), .evt_code_i(evt_code_i), .evt_param_i(evt_param_i),
        .exit_valid_o(exit_valid_o), .exit_code_o(exit_code_o), .exit_info_o(exit_info_o)
    );

    // monitor: every exit pulse must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && exit_valid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R1/R6 unexpected exit: actual code=%h info=%h expected none",
                         exit_code_o, exit_info_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (exit_code_o !== e.code || exit_info_o !== e.param) begin
                    fails++;
                    $display("FAIL %s R7: actual code=%h info=%h expected code=%h info=%h",
                             e.tag, exit_code_o, exit_info_o, e.code, e.param);
                end
            end
        end
    end

    task automatic check_drained(input string tag);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s R10: actual missing exit, expected code=%h info=%h",
                     tag, exp_q[0].code, exp_q[0].param);
            exp_q.delete();
        end
    endtask

    task automatic do_enter(input logic [63:0] g, input logic [15:0] crr, input logic [15:0] crw,
                            input logic [15:0] drr, input logic [15:0] drw, input logic [31:0] ex);
        @(negedge clk);
        enter_i = 1'b1; enter_generic_i = g; enter_cr_rd_i = crr; enter_cr_wr_i = crw;
        enter_dr_rd_i = drr; enter_dr_wr_i = drw; enter_exc_i = ex;
        @(posedge clk); #1;
        enter_i = 1'b0;
    endtask

    task automatic do_leave();
        @(negedge clk);
        leave_i = 1'b1;
        @(posedge clk); #1;
        leave_i = 1'b0;
    endtask

    task automatic send(input logic [11:0] code, input logic [63:0] param,
                        input bit hit, input string tag);
        @(negedge clk);
        evt_valid_i = 1'b1; evt_code_i = code; evt_param_i = param;
        if (hit) exp_q.push_back('{code, param, tag});
        @(posedge clk); #1;
        evt_valid_i = 1'b0;
        @(negedge clk); #1;
        check_drained(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual run still active, expected finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (exit_valid_o !== 1'b0 || exit_code_o !== '0 || exit_info_o !== '0) begin
            fails++;
            $display("FAIL reset R10: actual v=%b code=%h info=%h expected 0/0/0",
                     exit_valid_o, exit_code_o, exit_info_o);
        end

        // R1: enable clear after reset, then after leave with CR masks still populated
        send(12'h000, 64'h11, 1'b0, "R1 after reset");
        do_enter('1, '1, '1, '1, '1, '1);
        do_leave();
        send(12'h003, 64'h12, 1'b0, "R1 after leave");

        do_enter(64'h8000_0000_0000_0001, 16'h0205, 16'h0100, 16'h0180, 16'h0001,
                 32'h8000_0002);
        send(12'h000, 64'hA000, 1'b1, "R2 cr_rd bit0");
        send(12'h001, 64'hA001, 1'b0, "R2 cr_rd bit1 clear");
        send(12'h002, 64'hA002, 1'b1, "R2 cr_rd bit2");
        send(12'h009, 64'hA009, 1'b0, "R6 gap above cr_rd (mask bit9 set)");
        send(12'h018, 64'hB018, 1'b1, "R3 cr_wr bit8");
        send(12'h017, 64'hB017, 1'b0, "R3 cr_wr bit7 clear");
        send(12'h027, 64'hC027, 1'b1, "R4 dr_rd bit7");
        send(12'h028, 64'hC028, 1'b0, "R4 gap after dr_rd (mask bit8 set)");
        send(12'h030, 64'hD030, 1'b1, "R4 dr_wr bit0");
        send(12'h031, 64'hD031, 1'b0, "R4 dr_wr bit1 clear");
        send(12'h041, 64'hE041, 1'b1, "R5 exc bit1");
        send(12'h05F, 64'hE05F, 1'b1, "R5 exc bit31");
        send(12'h040, 64'hE040, 1'b0, "R5 exc bit0 clear");
        send(12'h060, 64'hF060, 1'b1, "R6 generic bit0");
        send(12'h09F, 64'hF09F, 1'b1, "R6 generic bit63");
        send(12'h061, 64'hF061, 1'b0, "R6 generic bit1 clear");
        send(12'h0A0, 64'hF0A0, 1'b0, "R6 above generic");
        send(12'hFFF, 64'hFFFF, 1'b0, "R6 top code");

        // R10: two events on consecutive cycles give two exits
        @(negedge clk);
        evt_valid_i = 1'b1; evt_code_i = 12'h000; evt_param_i = 64'h1234;
        exp_q.push_back('{12'h000, 64'h1234, "R10 burst first"});
        @(posedge clk); #1;
        evt_code_i = 12'h060; evt_param_i = 64'h5678;
        exp_q.push_back('{12'h060, 64'h5678, "R10 burst second"});
        @(posedge clk); #1;
        evt_valid_i = 1'b0;
        @(negedge clk); @(negedge clk); #1;
        check_drained("R10 burst");
        checks++;
        if (exit_valid_o !== 1'b0 || exit_code_o !== 12'h060 || exit_info_o !== 64'h5678) begin
            fails++;
            $display("FAIL R10 hold: actual v=%b code=%h info=%h expected 0/060/5678",
                     exit_valid_o, exit_code_o, exit_info_o);
        end

        // R9: event in the entry cycle uses the old masks
        @(negedge clk);
        enter_i = 1'b1; enter_cr_rd_i = 16'h0002; enter_generic_i = 64'h1;
        enter_exc_i = 32'h2;
        evt_valid_i = 1'b1; evt_code_i = 12'h000; evt_param_i = 64'h9000;
        exp_q.push_back('{12'h000, 64'h9000, "R9 same-cycle old mask"});
        @(posedge clk); #1;
        enter_i = 1'b0; evt_valid_i = 1'b0;
        @(negedge clk); #1;
        check_drained("R9 same-cycle");
        send(12'h001, 64'h9001, 1'b1, "R9 new mask bit1");
        send(12'h000, 64'h9002, 1'b0, "R9 new mask bit0 clear");

        // R8: leave clears enable, generic and exception masks
        do_leave();
        send(12'h060, 64'h8060, 1'b0, "R8 generic after leave");
        send(12'h041, 64'h8041, 1'b0, "R8 exc after leave");

        // R9: coincident leave and entry, leave wins
        do_enter('1, '1, '1, '1, '1, '1);
        send(12'h005, 64'h7005, 1'b1, "R9 re-entry works");
        @(negedge clk);
        enter_i = 1'b1; leave_i = 1'b1;
        @(posedge clk); #1;
        enter_i = 1'b0; leave_i = 1'b0;
        send(12'h005, 64'h7006, 1'b0, "R9 leave beats entry");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule